// File: doc/BRIEF.md
# Masked Scan Shift-and-Compare Engine

This block runs one shift-and-compare pass over a boundary-scan chain. A controller first programs a TCK cycle count. It then issues a start with three words of equal length: the bits to shift in, the bits it expects to come back, and a mask. The mask marks which of the returned bits are known. The engine clocks the chosen one of two chains for exactly the programmed number of TCK cycles. It feeds the stimulus most-significant bit first on TDI. On each rising TCK edge it checks the TDO bit against the matching expected bit, but only where the mask bit is 1.

The engine never works out the shift length from the data. The length is always the value last written to its count register. A start issued before any count was written, or with a count of zero, produces no TCK activity and ends at once. Each chain owns a bank of eight sticky error flags. The command picks which flag a mismatch sets. The flag stays set until the same chain and flag index are named together with a clear request.

The control core is a four-state machine:
- `S_IDLE` waits for a start.
- `S_LOW` holds TCK low with TDI settled.
- `S_HIGH` holds TCK high.
- `S_DONE` lasts one clock and raises done.

The transitions are:
- From `S_IDLE` to `S_LOW` on a start with a non-zero loaded count.
- From `S_IDLE` to `S_DONE` on a start with no usable count.
- From `S_LOW` to `S_HIGH` when the half-period timer expires. This is the rising TCK edge, and TDO is sampled here.
- From `S_HIGH` to `S_LOW` when the timer expires and bits remain. This is the falling TCK edge, and the next stimulus bit is driven here.
- From `S_HIGH` to `S_DONE` when the timer expires on the last bit.
- From `S_DONE` to `S_IDLE` unconditionally.

Top module: `scan_cmp_engine`

## Requirements
- R1: After reset, and whenever the engine is not busy, every `tck_o` and `tdi_o` bit is 0, `busy` and `done` are 0, and after reset all of `err_flags` are 0.
- R2: While not busy, `cnt_load` stores `cnt_value` into the count register. Values above `MAX_LEN` (64) are clamped to `MAX_LEN`. A load while busy is ignored. A started pass produces exactly as many TCK rising edges as the stored count.
- R3: A start issued before any count load since reset, or with a stored count of 0, produces no TCK edge. It raises `done` in the first clock after the start and leaves the flags unchanged.
- R4: With a count N, bit `stim_vec[N-1]` is shifted first and `stim_vec[0]` last. After the pass, chain cell j (cell 0 next to TDI, cell N-1 next to TDO) holds `stim_vec[j]`.
- R5: TCK stays high for `HALF` clocks and low for `HALF` clocks per bit. TDI changes only on the clock where TCK falls or where a pass begins, never while TCK is high.
- R6: On the k-th rising TCK edge (k = 1..N) the sampled TDO bit is compared with `exp_vec[N-k]` only when `mask_vec[N-k]` is 1. The result is that the prior content of cell j is checked against `exp_vec[j]` wherever `mask_vec[j]` is 1.
- R7: A masked mismatch sets `err_flags[chain_sel*8 + flag_sel]` and no other flag. Flags are sticky across later passes that match.
- R8: `flag_clr` clears `err_flags[chain_sel*8 + flag_sel]` on the next clock. A set in the same clock takes priority over the clear.
- R9: Only the selected chain receives TCK edges. The other chain's `tck_o` and `tdi_o` stay 0.
- R10: `busy` is 1 from the clock after an accepted start until the last falling TCK edge. `done` is high for exactly one clock, `2*HALF*N + 1` clocks after the start is sampled. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_load | input | 1 | Write `cnt_value` into the count register |
| cnt_value | input | 7 | TCK cycle count to store |
| start | input | 1 | Begin one shift-and-compare pass |
| chain_sel | input | 1 | Chain to drive, or chain of the flag to clear |
| flag_sel | input | 3 | Flag index to set on mismatch, or to clear |
| flag_clr | input | 1 | Clear the flag named by `chain_sel` and `flag_sel` |
| stim_vec | input | 64 | Stimulus bits; bit N-1 shifted first |
| exp_vec | input | 64 | Expected response; bit j belongs to cell j |
| mask_vec | input | 64 | Compare enable per position; 1 means compare |
| tdo_i | input | 2 | Serial data returned from each chain |
| tck_o | output | 2 | Test clock toward each chain |
| tdi_o | output | 2 | Serial data toward each chain |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-clock pulse at the end of a pass |
| err_flags | output | 16 | Sticky error flags, chain c flag f at bit c*8+f |

## Verification
If the bit index is wrong, the chain ends up holding a rotated or truncated copy of the stimulus. The cell check exposes this right after `done`, and the flag check exposes it when a masked mismatch is missed or invented. A timer or state-transition fault shows up in the same pass as a wrong number of TCK rising edges or a shifted `done` clock. A fault in the output demultiplexer shows up as edges on the unselected chain. Faults in flag storage become visible on `err_flags` in the clock after the set or clear.

// File: rtl/scan_cmp_pkg.sv
package scan_cmp_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOW  = 2'd1,
        S_HIGH = 2'd2,
        S_DONE = 2'd3
    } eng_state_t;

    // one masked comparison: high when a known position disagrees
    function automatic logic masked_miss(input logic got, input logic want, input logic known);
        return known & (got ^ want);
    endfunction

endpackage

// File: rtl/scan_len_reg.sv
module scan_len_reg #(
    parameter int MAX_LEN = 64,
    parameter int CW      = $clog2(MAX_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          allow,
    input  logic [CW-1:0] value,
    output logic [CW-1:0] len_q,
    output logic          len_ok
);

    localparam logic [CW-1:0] LEN_CAP = CW'(MAX_LEN);

    logic [CW-1:0] clamped;

    always_comb begin
        clamped = (value > LEN_CAP) ? LEN_CAP : value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            len_ok <= 1'b0;
        end else if (load && allow) begin
            len_q  <= clamped;
            len_ok <= 1'b1;
        end
    end

endmodule

// File: rtl/scan_err_bank.sv
module scan_err_bank #(
    parameter int NCHAIN = 2,
    parameter int NFLAG  = 8,
    parameter int SELW   = (NCHAIN > 1) ? $clog2(NCHAIN) : 1,
    parameter int FSW    = (NFLAG > 1) ? $clog2(NFLAG) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    set_en,
    input  logic [SELW-1:0]         set_chain,
    input  logic [FSW-1:0]          set_idx,
    input  logic                    clr_en,
    input  logic [SELW-1:0]         clr_chain,
    input  logic [FSW-1:0]          clr_idx,
    output logic [NCHAIN*NFLAG-1:0] flags
);

    for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
        for (genvar f = 0; f < NFLAG; f++) begin : g_flag
            logic hit_set;
            logic hit_clr;
            logic bit_q;

            always_comb begin
                hit_set = set_en && (set_chain == SELW'(c)) && (set_idx == FSW'(f));
                hit_clr = clr_en && (clr_chain == SELW'(c)) && (clr_idx == FSW'(f));
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else if (hit_set) begin
                    bit_q <= 1'b1;
                end else if (hit_clr) begin
                    bit_q <= 1'b0;
                end
            end

            assign flags[c*NFLAG + f] = bit_q;
        end
    end

endmodule

// File: rtl/scan_shift_fsm.sv
module scan_shift_fsm
    import scan_cmp_pkg::*;
#(
    parameter int MAX_LEN = 64,
    parameter int HALF    = 2,
    parameter int NCHAIN  = 2,
    parameter int NFLAG   = 8,
    parameter int CW      = $clog2(MAX_LEN + 1),
    parameter int IW      = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
    parameter int SELW    = (NCHAIN > 1) ? $clog2(NCHAIN) : 1,
    parameter int FSW     = (NFLAG > 1) ? $clog2(NFLAG) : 1,
    parameter int TW      = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CW-1:0]      len_q,
    input  logic               len_ok,
    input  logic [SELW-1:0]    chain_sel,
    input  logic [FSW-1:0]     flag_sel,
    input  logic [MAX_LEN-1:0] stim_vec,
    input  logic [MAX_LEN-1:0] exp_vec,
    input  logic [MAX_LEN-1:0] mask_vec,
    input  logic               tdo_bit,
    output logic               busy,
    output logic               done,
    output logic               tck_int,
    output logic               tdi_int,
    output logic [SELW-1:0]    act_chain,
    output logic [FSW-1:0]     act_flag,
    output logic               cmp_fail
);

    localparam logic [TW-1:0] TICK_AT = TW'(HALF - 1);

    eng_state_t         state_q;
    eng_state_t         state_d;
    logic [TW-1:0]      tmr_q;
    logic [IW-1:0]      idx_q;
    logic [MAX_LEN-1:0] stim_q;
    logic [MAX_LEN-1:0] exp_q;
    logic [MAX_LEN-1:0] mask_q;
    logic               tdi_q;
    logic               tick;
    logic               go_shift;
    logic [IW-1:0]      first_idx;

    always_comb begin
        tick      = (tmr_q == TICK_AT);
        go_shift  = len_ok && (len_q != '0);
        first_idx = IW'(len_q - CW'(1));
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = go_shift ? S_LOW : S_DONE;
                end
            end
            S_LOW: begin
                if (tick) begin
                    state_d = S_HIGH;
                end
            end
            S_HIGH: begin
                if (tick) begin
                    state_d = (idx_q == '0) ? S_DONE : S_LOW;
                end
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // half-period timer, bit pointer, captured command and TDI register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q     <= '0;
            idx_q     <= '0;
            stim_q    <= '0;
            exp_q     <= '0;
            mask_q    <= '0;
            act_chain <= '0;
            act_flag  <= '0;
            tdi_q     <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    tmr_q <= '0;
                    if (start && go_shift) begin
                        stim_q    <= stim_vec;
                        exp_q     <= exp_vec;
                        mask_q    <= mask_vec;
                        act_chain <= chain_sel;
                        act_flag  <= flag_sel;
                        idx_q     <= first_idx;
                        tdi_q     <= stim_vec[first_idx];
                    end
                end
                S_LOW: begin
                    tmr_q <= tick ? '0 : tmr_q + TW'(1);
                end
                S_HIGH: begin
                    if (tick) begin
                        tmr_q <= '0;
                        if (idx_q == '0) begin
                            tdi_q <= 1'b0;
                        end else begin
                            idx_q <= idx_q - IW'(1);
                            tdi_q <= stim_q[idx_q - IW'(1)];
                        end
                    end else begin
                        tmr_q <= tmr_q + TW'(1);
                    end
                end
                S_DONE: begin
                    tmr_q <= '0;
                    tdi_q <= 1'b0;
                end
                default: begin
                    tmr_q <= '0;
                end
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        busy     = 1'b0;
        done     = 1'b0;
        tck_int  = 1'b0;
        cmp_fail = 1'b0;
        unique case (state_q)
            S_IDLE: begin
            end
            S_LOW: begin
                busy     = 1'b1;
                cmp_fail = tick && masked_miss(tdo_bit, exp_q[idx_q], mask_q[idx_q]);
            end
            S_HIGH: begin
                busy    = 1'b1;
                tck_int = 1'b1;
            end
            S_DONE: begin
                done = 1'b1;
            end
            default: begin
            end
        endcase
        tdi_int = tdi_q;
    end

endmodule

// File: rtl/scan_cmp_engine.sv
module scan_cmp_engine #(
    parameter int MAX_LEN = 64,
    parameter int HALF    = 2,
    parameter int NCHAIN  = 2,
    parameter int NFLAG   = 8,
    localparam int CW     = $clog2(MAX_LEN + 1),
    localparam int SELW   = (NCHAIN > 1) ? $clog2(NCHAIN) : 1,
    localparam int FSW    = (NFLAG > 1) ? $clog2(NFLAG) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cnt_load,
    input  logic [CW-1:0]           cnt_value,
    input  logic                    start,
    input  logic [SELW-1:0]         chain_sel,
    input  logic [FSW-1:0]          flag_sel,
    input  logic                    flag_clr,
    input  logic [MAX_LEN-1:0]      stim_vec,
    input  logic [MAX_LEN-1:0]      exp_vec,
    input  logic [MAX_LEN-1:0]      mask_vec,
    input  logic [NCHAIN-1:0]       tdo_i,
    output logic [NCHAIN-1:0]       tck_o,
    output logic [NCHAIN-1:0]       tdi_o,
    output logic                    busy,
    output logic                    done,
    output logic [NCHAIN*NFLAG-1:0] err_flags
);

    logic [CW-1:0]   len_q;
    logic            len_ok;
    logic            tck_int;
    logic            tdi_int;
    logic [SELW-1:0] act_chain;
    logic [FSW-1:0]  act_flag;
    logic            cmp_fail;
    logic            tdo_bit;

    scan_len_reg #(
        .MAX_LEN (MAX_LEN),
        .CW      (CW)
    ) u_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cnt_load),
        .allow  (!busy),
        .value  (cnt_value),
        .len_q  (len_q),
        .len_ok (len_ok)
    );

    scan_shift_fsm #(
        .MAX_LEN (MAX_LEN),
        .HALF    (HALF),
        .NCHAIN  (NCHAIN),
        .NFLAG   (NFLAG)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .len_q     (len_q),
        .len_ok    (len_ok),
        .chain_sel (chain_sel),
        .flag_sel  (flag_sel),
        .stim_vec  (stim_vec),
        .exp_vec   (exp_vec),
        .mask_vec  (mask_vec),
        .tdo_bit   (tdo_bit),
        .busy      (busy),
        .done      (done),
        .tck_int   (tck_int),
        .tdi_int   (tdi_int),
        .act_chain (act_chain),
        .act_flag  (act_flag),
        .cmp_fail  (cmp_fail)
    );

    scan_err_bank #(
        .NCHAIN (NCHAIN),
        .NFLAG  (NFLAG)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (cmp_fail),
        .set_chain (act_chain),
        .set_idx   (act_flag),
        .clr_en    (flag_clr),
        .clr_chain (chain_sel),
        .clr_idx   (flag_sel),
        .flags     (err_flags)
    );

    assign tdo_bit = tdo_i[act_chain];

    // steer the serial pair to the active chain only
    for (genvar c = 0; c < NCHAIN; c++) begin : g_port
        logic sel_here;
        assign sel_here = busy && (act_chain == SELW'(c));
        assign tck_o[c] = sel_here & tck_int;
        assign tdi_o[c] = sel_here & tdi_int;
    end

endmodule

// File: rtl/scan_cmp_engine_chk.sv
module scan_cmp_engine_chk #(
    parameter int NCHAIN = 2,
    parameter int NFLAG  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    flag_clr,
    input logic [NCHAIN-1:0]       tck_o,
    input logic [NCHAIN-1:0]       tdi_o,
    input logic                    busy,
    input logic                    done,
    input logic [NCHAIN*NFLAG-1:0] err_flags
);

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tck_o == '0) && (tdi_o == '0));  // R1

    AST_ONE_CHAIN_CLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tck_o) <= 1);  // R9

    AST_TDI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((tck_o & $past(tck_o)) != '0) |-> $stable(tdi_o));  // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R10

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);  // R10

    AST_FLAG_SET_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_flags & ~$past(err_flags)) != '0) |-> $past(busy));  // R7

    AST_FLAG_SET_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(err_flags & ~$past(err_flags)) <= 1);  // R7

    AST_FLAG_CLEAR_ASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((~err_flags & $past(err_flags)) != '0) |-> $past(flag_clr));  // R8

endmodule

bind scan_cmp_engine scan_cmp_engine_chk #(
    .NCHAIN (NCHAIN),
    .NFLAG  (NFLAG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_clr  (flag_clr),
    .tck_o     (tck_o),
    .tdi_o     (tdi_o),
    .busy      (busy),
    .done      (done),
    .err_flags (err_flags)
);

// File: tb/scan_cmp_engine_tb.sv
module scan_cmp_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_T     = 2;
    localparam int MLEN       = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_load = 1'b0;
    logic [6:0]  cnt_value = '0;
    logic        start = 1'b0;
    logic [0:0]  chain_sel = '0;
    logic [2:0]  flag_sel = '0;
    logic        flag_clr = 1'b0;
    logic [63:0] stim_vec = '0;
    logic [63:0] exp_vec = '0;
    logic [63:0] mask_vec = '0;
    logic [1:0]  tdo_i;
    logic [1:0]  tck_o;
    logic [1:0]  tdi_o;
    logic        busy;
    logic        done;
    logic [15:0] err_flags;

    int tests = 0;
    int fails = 0;

    // bench-side models
    logic [63:0] sr [2];
    logic        tdo_m [2];
    int          clen [2];
    int          rises [2];
    int          tdi_bad = 0;
    logic [15:0] exp_flags = '0;
    int          tb_len = 0;
    bit          tb_len_ok = 1'b0;
    logic [1:0]  prev_tck = '0;
    logic [1:0]  prev_tdi = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    scan_cmp_engine #(
        .MAX_LEN (MLEN),
        .HALF    (HALF_T)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_load  (cnt_load),
        .cnt_value (cnt_value),
        .start     (start),
        .chain_sel (chain_sel),
        .flag_sel  (flag_sel),
        .flag_clr  (flag_clr),
        .stim_vec  (stim_vec),
        .exp_vec   (exp_vec),
        .mask_vec  (mask_vec),
        .tdo_i     (tdo_i),
        .tck_o     (tck_o),
        .tdi_o     (tdi_o),
        .busy      (busy),
        .done      (done),
        .err_flags (err_flags)
    );

    assign tdo_i = {tdo_m[1], tdo_m[0]};

    // chain models: capture TDI on rising TCK, update TDO on falling TCK
    always @(posedge tck_o[0]) begin
        sr[0] <= {sr[0][62:0], tdi_o[0]};
        rises[0] <= rises[0] + 1;
    end
    always @(negedge tck_o[0]) tdo_m[0] <= sr[0][clen[0]-1];
    always @(posedge tck_o[1]) begin
        sr[1] <= {sr[1][62:0], tdi_o[1]};
        rises[1] <= rises[1] + 1;
    end
    always @(negedge tck_o[1]) tdo_m[1] <= sr[1][clen[1]-1];

    // TDI must not move while TCK stays high (sampled between edges)
    always @(negedge clk) begin
        for (int c = 0; c < 2; c++) begin
            if (prev_tck[c] && tck_o[c] && (prev_tdi[c] != tdi_o[c])) tdi_bad++;
        end
        prev_tck <= tck_o;
        prev_tdi <= tdi_o;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic load_count(input int v);
        @(negedge clk);
        cnt_value = 7'(v);
        cnt_load  = 1'b1;
        @(negedge clk);
        cnt_load  = 1'b0;
        tb_len    = (v > MLEN) ? MLEN : v;
        tb_len_ok = 1'b1;
    endtask

    task automatic clear_flag(input int c, input int f);
        @(negedge clk);
        chain_sel = 1'(c);
        flag_sel  = 3'(f);
        flag_clr  = 1'b1;
        @(negedge clk);
        flag_clr  = 1'b0;
        exp_flags[c*8+f] = 1'b0;
        check("R8 flag cleared", 64'(err_flags), 64'(exp_flags));
    endtask

    // one pass; poke=1 tries a second start and a count load mid-pass
    task automatic do_op(input int c, input int f, input logic [63:0] st, input logic [63:0] ex,
                         input logic [63:0] mk, input logic [63:0] pre, input bit poke, input string tag);
        int n;
        int lat;
        logic [63:0] lmask;
        logic [63:0] other;
        n = tb_len_ok ? tb_len : 0;
        lmask = (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
        sr[c] = pre;
        clen[c] = (n == 0) ? 1 : n;
        tdo_m[c] = pre[clen[c]-1];
        other = sr[1-c];
        rises[0] = 0;
        rises[1] = 0;
        if (((pre ^ ex) & mk & lmask) != '0) exp_flags[c*8+f] = 1'b1;
        @(negedge clk);
        chain_sel = 1'(c);
        flag_sel  = 3'(f);
        stim_vec  = st;
        exp_vec   = ex;
        mask_vec  = mk;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        if (n > 0) check({tag, " R10 busy after start"}, 64'(busy), 64'd1);
        if (poke) begin
            repeat (3) @(negedge clk);
            lat += 3;
            stim_vec  = ~st;
            start     = 1'b1;
            cnt_value = 7'd5;
            cnt_load  = 1'b1;
            @(negedge clk);
            lat++;
            start    = 1'b0;
            cnt_load = 1'b0;
        end
        while (!done && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        check({tag, " R10 done latency"}, 64'(lat), 64'(2 * HALF_T * n + 1));
        check({tag, " R2 tck rising edges"}, 64'(rises[c]), 64'(n));
        check({tag, " R9 other chain quiet"}, 64'(rises[1-c]), 64'd0);
        check({tag, " R9 other chain content"}, sr[1-c], other);
        if (n > 0) check({tag, " R4 chain content"}, sr[c] & lmask, st & lmask);
        check({tag, " R6 R7 error flags"}, 64'(err_flags), 64'(exp_flags));
        @(negedge clk);
        check({tag, " R10 done one clock"}, 64'(done), 64'd0);
        check({tag, " R1 idle outputs"}, 64'({busy, tck_o, tdi_o}), 64'd0);
    endtask

    initial begin
        void'($urandom(32'h5CA1_1E57));
        sr[0] = '0;
        sr[1] = '0;
        tdo_m[0] = 1'b0;
        tdo_m[1] = 1'b0;
        clen[0] = 1;
        clen[1] = 1;
        rises[0] = 0;
        rises[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset outputs", 64'({busy, done, tck_o, tdi_o}), 64'd0);
        check("R1 reset flags", 64'(err_flags), 64'd0);

        // no count loaded yet, then a zero count
        do_op(0, 0, 64'hFFFF, 64'h0, '1, 64'h0, 1'b0, "R3 no load");
        load_count(0);
        do_op(1, 2, 64'hFFFF, 64'h0, '1, 64'h0, 1'b0, "R3 zero count");

        // 16-cell pass: known positions match, unknown ones differ
        load_count(16);
        do_op(0, 1, 64'h5500, 64'h0309, 64'h0F0F, 64'hF309, 1'b0, "R6 masked match");
        do_op(0, 1, 64'h5500, 64'h0309, 64'h0000, 64'hFFFF, 1'b0, "R6 mask all off");
        do_op(0, 1, 64'h5500, 64'h0309, 64'h0001, 64'h0308, 1'b0, "R7 lsb mismatch");
        do_op(0, 1, 64'h1234, 64'h0000, 64'h8000, 64'h8000, 1'b0, "R6 msb mismatch");
        do_op(0, 1, 64'hABCD, 64'h1111, 64'hFFFF, 64'h1111, 1'b0, "R7 sticky");
        clear_flag(0, 1);
        clear_flag(1, 7);

        // start and load while busy are both ignored
        do_op(1, 3, 64'hC3A5, 64'h0, 64'h0, 64'h0, 1'b1, "R10 R2 busy ignore");
        do_op(1, 4, 64'h0F0F, 64'h0, 64'h0, 64'h0, 1'b0, "R2 count kept");

        // clamp above the chain limit
        load_count(100);
        do_op(1, 5, 64'hDEAD_BEEF_0123_4567, 64'h0, 64'h0, 64'h0, 1'b0, "R2 clamp");

        // one-bit pass
        load_count(1);
        do_op(0, 6, 64'h1, 64'h1, 64'h1, 64'h0, 1'b0, "R4 one bit");

        for (int i = 0; i < 40; i++) begin
            logic [63:0] st;
            logic [63:0] ex;
            logic [63:0] mk;
            logic [63:0] pr;
            st = {$urandom, $urandom};
            pr = {$urandom, $urandom};
            mk = {$urandom, $urandom} & {$urandom, $urandom};
            ex = ($urandom_range(0, 1) == 1) ? pr : (pr ^ (64'd1 << $urandom_range(0, 63)));
            load_count($urandom_range(1, 64));
            do_op(int'($urandom_range(0, 1)), int'($urandom_range(0, 7)), st, ex, mk, pr, 1'b0, "rand");
            if ($urandom_range(0, 3) == 0) clear_flag(int'($urandom_range(0, 1)), int'($urandom_range(0, 7)));
        end

        check("R5 tdi steady while tck high", 64'(tdi_bad), 64'd0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule